// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block buffers instruction bytes between a bus interface and an execution unit. The bus side delivers 16-bit code words and the execution side takes one byte at a time. The execution unit has no other path to code memory, so every instruction byte it sees passes through this queue.

The block keeps a fetch offset inside the code segment. It forms the physical fetch address from that offset and a segment base, and it asks the bus for a word whenever at least two byte slots are free. At most one fetch is outstanding at a time: a fetch is accepted with a grant and finishes with a done pulse that carries the data.

On a control transfer the execution side pulses a flush. The flush empties the queue, loads a new fetch offset and makes sure that any fetch still outstanding leaves no data behind. When the fetch offset is odd, only one byte is taken from the returned word, so that every later fetch is word-aligned.

Top module: `ifq_prefetch`

## Requirements
- R1: The queue holds at most 6 bytes and hands them out in the order they were written. `byte_valid` is high exactly when at least one byte is held, and `byte_out` then shows the oldest byte.
- R2: `fetch_addr` equals `seg_base` times 16 plus the current fetch offset, truncated to 20 bits.
- R3: `fetch_req` is high exactly when no fetch is outstanding, `flush` is low and at least 2 byte slots are free. After reset the queue is empty, the offset is 0 and `fetch_req` is high.
- R4: A fetch starts when `fetch_gnt` is high in a cycle where `fetch_req` is high, and it completes when `fetch_done` is pulsed with `fetch_data`. For an even offset, bits [7:0] are queued first, then bits [15:8], and the offset advances by 2.
- R5: For an odd offset, only `fetch_data[15:8]` is queued and the offset advances by 1.
- R6: A `flush` cycle leaves the queue empty in the next cycle and loads `flush_off` as the fetch offset. A `byte_take` in the same cycle as the flush has no effect.
- R7: If a fetch is outstanding during a `flush`, or completes in the flush cycle, its data is never queued and the offset is not advanced.
- R8: A `byte_take` while the queue is empty is ignored. A byte arriving in the same cycle as a take is kept, and it leaves in its proper order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_base | input | 16 | Code segment base |
| flush | input | 1 | Discard the contents and reload the offset |
| flush_off | input | 16 | Fetch offset loaded on flush |
| fetch_req | output | 1 | Request for one code word |
| fetch_addr | output | 20 | Physical address of the requested word |
| fetch_gnt | input | 1 | Bus accepts the request |
| fetch_done | input | 1 | Outstanding fetch completes this cycle |
| fetch_data | input | 16 | Returned code word |
| byte_out | output | 8 | Oldest queued byte |
| byte_valid | output | 1 | Queue is not empty |
| byte_take | input | 1 | Consume the oldest byte |

## Verification
On every cycle, the assertions check the occupancy bound, the agreement between the request and the free space, and that the queue is empty after a flush. They also check that a take on an empty queue leaves it empty, that the offset is even again after an odd fetch, that a flush loads the offset, and that a fetch cut short by a flush pushes nothing. Byte ordering, the address arithmetic and the loss of in-flight data only show up across whole scenarios. These are fills to full, draining past empty, odd flush targets, a flush between grant and completion, and long random mixes. In all of them a behavioural queue model in the bench predicts every output.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned WORD_W = 16;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [WORD_W-1:0] word_t;

   // number of bytes written into the ring by one completed fetch
   typedef enum logic [1:0] {
      PUSH_NONE = 2'd0,
      PUSH_ONE  = 2'd1,
      PUSH_TWO  = 2'd2
   } push_e;
endpackage

// File: rtl/ifq_ring.sv
module ifq_ring
   import ifq_pkg::*;
#(
   parameter  int unsigned DEPTH = 6,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  push_e            push_n,
   input  byte_t            push_b0,
   input  byte_t            push_b1,
   input  logic             pop,
   output byte_t            head,
   output logic [CNT_W-1:0] level
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ifq_ring: DEPTH must hold at least one word");
   end

   logic [PTR_W-1:0] wr_q, rd_q, wr_p1, wr_p2, rd_p1;
   byte_t            slot_q [DEPTH];

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_comb begin
      wr_p1 = bump(wr_q);
      wr_p2 = bump(wr_p1);
      rd_p1 = bump(rd_q);
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic sel_lo, sel_hi;
      assign sel_lo = (push_n != PUSH_NONE) && (wr_q == PTR_W'(i));
      assign sel_hi = (push_n == PUSH_TWO) && (wr_p1 == PTR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      slot_q[i] <= '0;
         else if (sel_lo) slot_q[i] <= push_b0;
         else if (sel_hi) slot_q[i] <= push_b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         level <= '0;
      end else if (flush) begin
         wr_q  <= '0;
         rd_q  <= '0;
         level <= '0;
      end else begin
         if (push_n == PUSH_TWO)      wr_q <= wr_p2;
         else if (push_n == PUSH_ONE) wr_q <= wr_p1;
         if (pop) rd_q <= rd_p1;
         level <= level + CNT_W'(push_n) - CNT_W'(pop);
      end
   end

   assign head = slot_q[rd_q];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      int'(push_n) + int'(level) <= int'(DEPTH)) else $error("ring overflow"); // R1

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> level == '0) else $error("flush left bytes"); // R6

   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0 && push_n == PUSH_NONE && !flush) |=> level == '0)
      else $error("pop on empty changed level"); // R8

endmodule

// File: rtl/ifq_fetch.sv
module ifq_fetch
   import ifq_pkg::*;
#(
   parameter  int unsigned DEPTH     = 6,
   parameter  int unsigned OFF_W     = 16,
   parameter  int unsigned SEG_W     = 16,
   parameter  int unsigned SEG_SHIFT = 4,
   parameter  int unsigned ADDR_W    = 20,
   localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  level,
   input  logic [SEG_W-1:0]  seg_base,
   input  logic              flush,
   input  logic [OFF_W-1:0]  flush_off,
   input  logic              gnt,
   input  logic              done,
   input  word_t             data,
   output logic              req,
   output logic [ADDR_W-1:0] addr,
   output push_e             push_n,
   output byte_t             push_b0,
   output byte_t             push_b1
);

   if (ADDR_W < OFF_W) begin : g_bad_addr
      $error("ifq_fetch: ADDR_W narrower than the offset");
   end

   logic [OFF_W-1:0] off_q;
   logic             busy_q, drop_q;
   logic             room, odd, land;

   assign room = level <= CNT_W'(DEPTH - 2);
   assign req  = !busy_q && !flush && room;
   assign odd  = off_q[0];
   assign land = done && busy_q && !drop_q && !flush;

   always_comb begin
      push_n  = PUSH_NONE;
      if (land) push_n = odd ? PUSH_ONE : PUSH_TWO;
      push_b0 = odd ? data[15:8] : data[7:0];
      push_b1 = data[15:8];
   end

   if (SEG_SHIFT == 0) begin : g_flat
      assign addr = ADDR_W'(seg_base) + ADDR_W'(off_q);
   end else begin : g_shifted
      assign addr = ADDR_W'({seg_base, {SEG_SHIFT{1'b0}}}) + ADDR_W'(off_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q  <= '0;
         busy_q <= 1'b0;
         drop_q <= 1'b0;
      end else if (flush) begin
         off_q  <= flush_off;
         busy_q <= busy_q && !done;
         drop_q <= busy_q && !done;
      end else begin
         if (land) off_q <= off_q + (odd ? OFF_W'(1) : OFF_W'(2));
         if (busy_q && done) begin
            busy_q <= 1'b0;
            drop_q <= 1'b0;
         end else if (req && gnt) begin
            busy_q <= 1'b1;
         end
      end
   end

   AST_ODD_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      push_n == PUSH_ONE |=> !off_q[0]) else $error("offset still odd"); // R5

   AST_FLUSH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> off_q == $past(flush_off)) else $error("flush offset lost"); // R6

   AST_STALE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && busy_q && !done) |=> push_n == PUSH_NONE)
      else $error("stale fetch pushed"); // R7

endmodule

// File: rtl/ifq_prefetch.sv
module ifq_prefetch
   import ifq_pkg::*;
#(
   parameter int unsigned DEPTH     = 6,
   parameter int unsigned OFF_W     = 16,
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned SEG_SHIFT = 4,
   parameter int unsigned ADDR_W    = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEG_W-1:0]  seg_base,
   input  logic              flush,
   input  logic [OFF_W-1:0]  flush_off,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_gnt,
   input  logic              fetch_done,
   input  logic [15:0]       fetch_data,
   output logic [7:0]        byte_out,
   output logic              byte_valid,
   input  logic              byte_take
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0] level;
   push_e            push_n;
   byte_t            push_b0, push_b1;
   logic             pop;

   assign byte_valid = level != '0;
   assign pop        = byte_take && byte_valid && !flush;

   ifq_fetch #(
      .DEPTH(DEPTH), .OFF_W(OFF_W), .SEG_W(SEG_W),
      .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .level(level), .seg_base(seg_base),
      .flush(flush), .flush_off(flush_off), .gnt(fetch_gnt),
      .done(fetch_done), .data(fetch_data), .req(fetch_req),
      .addr(fetch_addr), .push_n(push_n), .push_b0(push_b0),
      .push_b1(push_b1)
   );

   ifq_ring #(.DEPTH(DEPTH)) u_ring (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push_n(push_n),
      .push_b0(push_b0), .push_b1(push_b1), .pop(pop),
      .head(byte_out), .level(level)
   );

   AST_REQ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> int'(level) + 2 <= int'(DEPTH)) else $error("request without room"); // R3

endmodule

// File: tb/tb_ifq_prefetch.sv
module tb_ifq_prefetch;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] seg_base = 16'h1234;
   logic        flush = 1'b0;
   logic [15:0] flush_off = '0;
   logic        fetch_req;
   logic [19:0] fetch_addr;
   logic        fetch_gnt = 1'b0;
   logic        fetch_done = 1'b0;
   logic [15:0] fetch_data = '0;
   logic [7:0]  byte_out;
   logic        byte_valid;
   logic        byte_take = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   ifq_prefetch dut (
      .clk(clk), .rst_n(rst_n), .seg_base(seg_base), .flush(flush),
      .flush_off(flush_off), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_gnt(fetch_gnt), .fetch_done(fetch_done), .fetch_data(fetch_data),
      .byte_out(byte_out), .byte_valid(byte_valid), .byte_take(byte_take)
   );

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   // behavioural reference
   logic [7:0]  mq[$];
   logic [15:0] m_off = '0;
   bit          m_busy = 0;
   bit          m_drop = 0;
   int          lat = 0;
   bit          bus_auto = 0;

   function automatic logic [7:0] memb(input logic [19:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
   endfunction

   function automatic logic [19:0] exp_addr();
      return ({4'h0, seg_base} << 4) + {4'h0, m_off};
   endfunction

   function automatic bit m_req();
      return !m_busy && !flush && (6 - mq.size()) >= 2;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one clock cycle: inputs already driven, we are just after a falling edge
   task automatic cyc();
      bit req_now;
      logic [19:0] fa;
      if (bus_auto) begin
         fa = exp_addr();
         fetch_gnt  = m_req() && ($urandom % 3 != 0);
         fetch_done = m_busy && (lat == 0);
         fetch_data = {memb(fa | 20'h1), memb(fa & ~20'h1)};
      end
      #1;
      req_now = m_req();
      chk(byte_valid == (mq.size() > 0), "R1 R8 valid", byte_valid, mq.size() > 0);
      if (mq.size() > 0) chk(byte_out == mq[0], "R1 order", byte_out, mq[0]);
      chk(fetch_req == req_now, "R3 request", fetch_req, req_now);
      chk(fetch_addr == exp_addr(), "R2 address", fetch_addr, exp_addr());
      @(posedge clk);
      if (flush) begin
         mq.delete();
         if (m_busy && !fetch_done) m_drop = 1;
         else if (m_busy) begin m_busy = 0; m_drop = 0; end
         m_off = flush_off;
      end else begin
         if (byte_take && mq.size() > 0) void'(mq.pop_front());
         if (m_busy && fetch_done) begin
            if (!m_drop) begin
               if (m_off[0]) begin
                  mq.push_back(fetch_data[15:8]);
                  m_off = m_off + 16'd1;
               end else begin
                  mq.push_back(fetch_data[7:0]);
                  mq.push_back(fetch_data[15:8]);
                  m_off = m_off + 16'd2;
               end
            end
            m_busy = 0;
            m_drop = 0;
         end else if (req_now && fetch_gnt) begin
            m_busy = 1;
            lat = $urandom % 3;
         end else if (m_busy && lat > 0) begin
            lat--;
         end
      end
      @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [19:0] base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // reset state
      chk(byte_valid == 1'b0, "R1 reset empty", byte_valid, 0);
      chk(fetch_req == 1'b1, "R3 reset request", fetch_req, 1);
      chk(fetch_addr == 20'h12340, "R2 reset address", fetch_addr, 20'h12340);

      // fill to full with no consumer
      bus_auto = 1;
      repeat (40) cyc();
      #1;
      chk(fetch_req == 1'b0, "R3 full no request", fetch_req, 0);
      bus_auto = 0;
      fetch_gnt = 0;
      fetch_done = 0;

      // drain in order
      base = 20'h12340;
      for (int i = 0; i < 6; i++) begin
         byte_take = 1;
         #1;
         chk(byte_out == memb(base + 20'(i)), "R4 byte order", byte_out, memb(base + 20'(i)));
         cyc();
      end
      // takes on an empty queue
      repeat (3) begin
         #1;
         chk(byte_valid == 1'b0, "R8 empty take", byte_valid, 0);
         cyc();
      end
      byte_take = 0;
      bus_auto = 1;
      for (int i = 0; i < 20 && mq.size() == 0; i++) cyc();
      #1;
      chk(byte_out == memb(base + 20'd6), "R8 next byte after empty takes",
          byte_out, memb(base + 20'd6));

      // flush to an odd offset
      flush = 1;
      flush_off = 16'h0203;
      byte_take = 1;
      cyc();
      flush = 0;
      byte_take = 0;
      #1;
      chk(byte_valid == 1'b0, "R6 flush empties", byte_valid, 0);
      chk(fetch_addr == 20'h12543, "R6 flush offset", fetch_addr, 20'h12543);
      for (int i = 0; i < 30 && mq.size() < 2; i++) cyc();
      #1;
      chk(byte_out == memb(20'h12543), "R5 odd first byte", byte_out, memb(20'h12543));
      byte_take = 1;
      cyc();
      byte_take = 0;
      #1;
      chk(byte_out == memb(20'h12544), "R5 aligned next byte", byte_out, memb(20'h12544));

      // flush between grant and completion
      bus_auto = 0;
      fetch_gnt = 0;
      fetch_done = 0;
      while (m_busy) begin
         fetch_done = 1;
         cyc();
         fetch_done = 0;
      end
      flush = 1;
      flush_off = 16'h0400;
      cyc();
      flush = 0;
      fetch_gnt = 1;
      cyc();
      fetch_gnt = 0;
      flush = 1;
      flush_off = 16'h0500;
      cyc();
      flush = 0;
      fetch_done = 1;
      fetch_data = 16'hBEEF;
      cyc();
      fetch_done = 0;
      #1;
      chk(byte_valid == 1'b0, "R7 stale data dropped", byte_valid, 0);
      chk(fetch_addr == 20'h12840, "R7 offset not advanced", fetch_addr, 20'h12840);
      chk(fetch_req == 1'b1, "R7 request resumes", fetch_req, 1);

      // random mix
      bus_auto = 1;
      for (int i = 0; i < 3000; i++) begin
         byte_take = ($urandom % 2) == 1;
         flush = ($urandom % 40) == 0;
         flush_off = 16'($urandom);
         if ($urandom % 200 == 0) seg_base = 16'($urandom);
         cyc();
      end
      flush = 0;
      summary();
   end
endmodule